// File: doc/BRIEF.md
# Serial Flash Geometry Identifier

This block identifies an attached serial data flash when it is asked to, and reports the part's geometry. It drives the device as an SPI master in mode 0, sending the most significant bit first. It starts with the standard three-byte identification command. If the manufacturer byte is the expected one and the device code is in the block's table, the geometry comes from that table. For parts that can run with either page layout, one status read chooses between binary pages and extended pages.

If the identification does not give the expected manufacturer, the block reads the status byte once. It then takes the capacity class from four bits of that byte. The result is one of three outcomes: a valid geometry, an unsupported device, or no device present. The geometry is the page count, the page size in bytes, the address shift that places a page number above the byte offset, the page-mode flag, and the total capacity.

A boot or flash-management controller pulses the request once after reset. It waits for the one-cycle completion strobe and then reads the held fields.

Top module: `flash_geom_probe`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done`, `geom_valid`, `unsupported` and `no_device` are all 0.
- R2: A probe begins with one chip-select window. In that window the block sends opcode 0x9F and then clocks in three bytes: manufacturer, device high, device low. That window has exactly 32 SCK rising edges. MOSI is sampled by the device and MISO by the block on the rising edge, MSB first.
- R3: With manufacturer 0x1F, the device codes 0x2200, 0x2300, 0x2400, 0x2500, 0x2600, 0x2701 and 0x2800 cause a second window. That window carries opcode 0xD7 plus one status byte, 16 rising edges in all. Status bit 0 = 1 selects binary pages and bit 0 = 0 selects extended pages.
- R4: The page counts are 512, 1024, 2048, 4096, 4096, 8192 and 8192, in the R3 order. Extended size and shift are 264/9 for the first four codes, 528/10 for 0x2600 and 0x2701, and 1056/11 for 0x2800. The binary size is 8 bytes per 264 less, with a shift one smaller: 256/8, 512/9, 1024/10.
- R5: Manufacturer 0x1F with device code 0x2700 gives 8192 pages of 528 bytes, shift 10, extended mode, with no status window.
- R6: Manufacturer 0x1F with any device code not named in R3 or R5 gives `unsupported`, with no status window.
- R7: Any manufacturer other than 0x1F causes one 0xD7 status window. There, a status of 0x00 or 0xFF gives `no_device`.
- R8: Otherwise, on that path, status AND 0x3C selects the geometry, always in extended mode. 0x0C gives 512×264/9 and 0x14 gives 1024×264/9. 0x1C gives 2048×264/9 and 0x24 gives 4096×264/9. 0x2C gives 4096×528/10 and 0x34 gives 8192×528/10. 0x38 and 0x3C give 8192×1056/11.
- R9: On that path, any other masked code gives `unsupported`.
- R10: `total_bytes` equals `page_count` × `page_bytes` whenever `geom_valid` is 1.
- R11: `done` is a one-cycle pulse. In that cycle exactly one of `geom_valid`, `unsupported` and `no_device` is 1, and never more than one is 1 at any time. When the result is not valid, all geometry fields are 0.
- R12: The geometry fields change only in the `done` cycle and then hold. An accepted request clears the three result flags in the next cycle. A request made while `busy` is 1 is ignored.
- R13: `spi_sck` is 0 whenever `spi_cs_n` is 1. `spi_cs_n` is 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| probe_req | input | 1 | Start a probe (accepted only when idle) |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion strobe |
| geom_valid | output | 1 | Geometry fields are valid |
| unsupported | output | 1 | Device answered but is not decodable |
| no_device | output | 1 | Status read all-zero or all-one |
| page_count | output | 14 | Number of pages |
| page_bytes | output | 11 | Bytes per page |
| page_shift | output | 4 | Bit position of the page number in a device address |
| binary_pages | output | 1 | 1 when the part runs power-of-two pages |
| total_bytes | output | 24 | Capacity in bytes |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Data to device |
| spi_miso | input | 1 | Data from device |

## Verification
The assertions check the framing rules on every cycle: SCK stays low outside a select window and the select stays high while idle. They also check that the strobe lasts one cycle, that the result flags are exclusive, that the fields hold outside the strobe, and that the total equals count times size. Which geometry belongs to which identifier or status code can only be shown by scenarios. The bench sweeps all 256 status bytes on the fallback path and a grid of device codes, including unknown ones, with both page-mode bits. It also observes how many select windows each probe opened and which opcode each carried. That is how it shows that the status read is skipped for the fixed-layout part and for unknown parts.

// File: rtl/fgp_pkg.sv
package fgp_pkg;

  localparam int PCNT_W    = 14;
  localparam int PSIZE_W   = 11;
  localparam int SHIFT_W   = 4;
  localparam int TOTAL_W   = 24;
  localparam int LG_W      = 4;
  localparam int CLS_W     = 2;
  localparam int BIN_BASE  = 256;
  localparam int EXT_BASE  = BIN_BASE + BIN_BASE / 32;
  localparam int BIN_SHIFT = 8;

  localparam logic [7:0] OPC_IDENT  = 8'h9F;
  localparam logic [7:0] OPC_STATUS = 8'hD7;
  localparam logic [7:0] VENDOR_OK  = 8'h1F;

  typedef struct packed {
    logic [PCNT_W-1:0]  pages;
    logic [PSIZE_W-1:0] psize;
    logic [SHIFT_W-1:0] shift;
    logic               bin;
    logic [TOTAL_W-1:0] total;
  } geom_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_XFER, ST_END, ST_DECIDE
  } pstate_e;

  // Page count is a power of two, so capacity is a shift of the page size.
  function automatic geom_t make_geom(input logic [LG_W-1:0] lg,
                                      input logic [CLS_W-1:0] cls,
                                      input logic bin);
    geom_t g;
    g.pages = PCNT_W'(1) << lg;
    g.psize = (bin ? PSIZE_W'(BIN_BASE) : PSIZE_W'(EXT_BASE)) << cls;
    g.shift = (bin ? SHIFT_W'(BIN_SHIFT) : SHIFT_W'(BIN_SHIFT + 1)) + SHIFT_W'(cls);
    g.bin   = bin;
    g.total = TOTAL_W'(g.psize) << lg;
    return g;
  endfunction

endpackage

// File: rtl/fgp_spi_byte.sv
module fgp_spi_byte #(
  parameter int CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = $clog2(CLK_HALF + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HALF - 1);

  logic             busy_q, busy_d;
  logic             sck_q, sck_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       tx_q, tx_d;
  logic [7:0]       rx_q, rx_d;
  logic             tick;

  assign tick = busy_q && (div_q == DIV_LAST);

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        tx_d   = tx_byte;
        div_d  = '0;
        bit_d  = '0;
        sck_d  = 1'b0;
      end
    end else if (tick) begin
      div_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso};
      end else begin
        sck_d = 1'b0;
        if (bit_q == 3'd7) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          tx_d  = {tx_q[6:0], 1'b0};
        end
      end
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = tx_q[7];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  // R13
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && !sck_q);

endmodule

// File: rtl/fgp_decode.sv
module fgp_decode
  import fgp_pkg::*;
(
  input  logic [7:0] dev_hi,
  input  logic [7:0] dev_lo,
  input  logic [7:0] status,
  output logic       jed_known,
  output logic       jed_bincap,
  output geom_t      jed_bin_geom,
  output geom_t      jed_ext_geom,
  output logic       leg_absent,
  output logic       leg_known,
  output geom_t      leg_geom
);
  logic [LG_W-1:0]  jlg, llg;
  logic [CLS_W-1:0] jcls, lcls;

  always_comb begin
    jed_known  = 1'b1;
    jed_bincap = 1'b1;
    jlg        = LG_W'(9);
    jcls       = '0;
    case ({dev_hi, dev_lo})
      16'h2200: jlg = LG_W'(9);
      16'h2300: jlg = LG_W'(10);
      16'h2400: jlg = LG_W'(11);
      16'h2500: jlg = LG_W'(12);
      16'h2600: begin jlg = LG_W'(12); jcls = CLS_W'(1); end
      16'h2700: begin jlg = LG_W'(13); jcls = CLS_W'(1); jed_bincap = 1'b0; end
      16'h2701: begin jlg = LG_W'(13); jcls = CLS_W'(1); end
      16'h2800: begin jlg = LG_W'(13); jcls = CLS_W'(2); end
      default:  begin jed_known = 1'b0; jed_bincap = 1'b0; end
    endcase
    jed_bin_geom = make_geom(jlg, jcls, 1'b1);
    jed_ext_geom = make_geom(jlg, jcls, 1'b0);
  end

  always_comb begin
    leg_known = 1'b1;
    llg       = LG_W'(9);
    lcls      = '0;
    case (status[5:2])
      4'h3: llg = LG_W'(9);
      4'h5: llg = LG_W'(10);
      4'h7: llg = LG_W'(11);
      4'h9: llg = LG_W'(12);
      4'hB: begin llg = LG_W'(12); lcls = CLS_W'(1); end
      4'hD: begin llg = LG_W'(13); lcls = CLS_W'(1); end
      4'hE, 4'hF: begin llg = LG_W'(13); lcls = CLS_W'(2); end
      default: leg_known = 1'b0;
    endcase
    leg_absent = (status == 8'h00) || (status == 8'hFF);
    leg_geom   = make_geom(llg, lcls, 1'b0);
  end

endmodule

// File: rtl/fgp_ctrl.sv
module fgp_ctrl
  import fgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       probe_req,
  input  logic       xfer_done,
  input  logic [7:0] rx_byte,
  output logic       xfer_start,
  output logic [7:0] xfer_tx,
  output logic       cs_n,
  output logic [7:0] dev_hi,
  output logic [7:0] dev_lo,
  output logic [7:0] status,
  input  logic       jed_known,
  input  logic       jed_bincap,
  input  geom_t      jed_bin_geom,
  input  geom_t      jed_ext_geom,
  input  logic       leg_absent,
  input  logic       leg_known,
  input  geom_t      leg_geom,
  output logic       busy,
  output logic       done,
  output logic       geom_valid,
  output logic       unsupported,
  output logic       no_device,
  output geom_t      geom
);
  localparam logic [1:0] ID_LAST   = 2'd3;
  localparam logic [1:0] STAT_LAST = 2'd1;

  pstate_e    state_q, state_d;
  logic       stat_ph_q, stat_ph_d;
  logic [1:0] idx_q, idx_d;
  logic [7:0] mfr_q, mfr_d, dhi_q, dhi_d, dlo_q, dlo_d, st_q, st_d;
  logic       cs_q, cs_d;
  logic       done_q, done_d;
  logic       val_q, val_d, uns_q, uns_d, nod_q, nod_d;
  geom_t      geom_q, geom_d;

  always_comb begin
    state_d    = state_q;
    stat_ph_d  = stat_ph_q;
    idx_d      = idx_q;
    mfr_d      = mfr_q;
    dhi_d      = dhi_q;
    dlo_d      = dlo_q;
    st_d       = st_q;
    cs_d       = cs_q;
    done_d     = 1'b0;
    val_d      = val_q;
    uns_d      = uns_q;
    nod_d      = nod_q;
    geom_d     = geom_q;
    xfer_start = 1'b0;
    xfer_tx    = 8'h00;
    case (state_q)
      ST_IDLE: begin
        if (probe_req) begin
          state_d   = ST_START;
          stat_ph_d = 1'b0;
          val_d     = 1'b0;
          uns_d     = 1'b0;
          nod_d     = 1'b0;
        end
      end
      ST_START: begin
        cs_d       = 1'b0;
        xfer_start = 1'b1;
        xfer_tx    = stat_ph_q ? OPC_STATUS : OPC_IDENT;
        idx_d      = '0;
        state_d    = ST_XFER;
      end
      ST_XFER: begin
        if (xfer_done) begin
          if (stat_ph_q) begin
            if (idx_q == 2'd1) st_d = rx_byte;
          end else begin
            case (idx_q)
              2'd1:    mfr_d = rx_byte;
              2'd2:    dhi_d = rx_byte;
              2'd3:    dlo_d = rx_byte;
              default: ;
            endcase
          end
          if (idx_q == (stat_ph_q ? STAT_LAST : ID_LAST)) begin
            state_d = ST_END;
          end else begin
            idx_d      = idx_q + 2'd1;
            xfer_start = 1'b1;
          end
        end
      end
      ST_END: begin
        cs_d    = 1'b1;
        state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        geom_d  = '0;
        if (!stat_ph_q && (mfr_q == VENDOR_OK)) begin
          if (!jed_known) begin
            uns_d = 1'b1;
          end else if (jed_bincap) begin
            state_d   = ST_START;
            stat_ph_d = 1'b1;
            done_d    = 1'b0;
            geom_d    = geom_q;
          end else begin
            val_d  = 1'b1;
            geom_d = jed_ext_geom;
          end
        end else if (!stat_ph_q) begin
          state_d   = ST_START;
          stat_ph_d = 1'b1;
          done_d    = 1'b0;
          geom_d    = geom_q;
        end else if (mfr_q == VENDOR_OK) begin
          val_d  = 1'b1;
          geom_d = st_q[0] ? jed_bin_geom : jed_ext_geom;
        end else if (leg_absent) begin
          nod_d = 1'b1;
        end else if (leg_known) begin
          val_d  = 1'b1;
          geom_d = leg_geom;
        end else begin
          uns_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      stat_ph_q <= 1'b0;
      idx_q     <= '0;
      mfr_q     <= '0;
      dhi_q     <= '0;
      dlo_q     <= '0;
      st_q      <= '0;
      cs_q      <= 1'b1;
      done_q    <= 1'b0;
      val_q     <= 1'b0;
      uns_q     <= 1'b0;
      nod_q     <= 1'b0;
      geom_q    <= '0;
    end else begin
      state_q   <= state_d;
      stat_ph_q <= stat_ph_d;
      idx_q     <= idx_d;
      mfr_q     <= mfr_d;
      dhi_q     <= dhi_d;
      dlo_q     <= dlo_d;
      st_q      <= st_d;
      cs_q      <= cs_d;
      done_q    <= done_d;
      val_q     <= val_d;
      uns_q     <= uns_d;
      nod_q     <= nod_d;
      geom_q    <= geom_d;
    end
  end

  assign cs_n        = cs_q;
  assign dev_hi      = dhi_q;
  assign dev_lo      = dlo_q;
  assign status      = st_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign geom_valid  = val_q;
  assign unsupported = uns_q;
  assign no_device   = nod_q;
  assign geom        = geom_q;

  // R13
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_q);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R11
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({val_q, uns_q, nod_q}));

  // R11
  done_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $countones({val_q, uns_q, nod_q}) == 1);

  // R12
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(geom_q));

  // R12
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && probe_req) |=> busy && !val_q && !uns_q && !nod_q);

endmodule

// File: rtl/flash_geom_probe.sv
module flash_geom_probe
  import fgp_pkg::*;
#(
  parameter int CLK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               probe_req,
  output logic               busy,
  output logic               done,
  output logic               geom_valid,
  output logic               unsupported,
  output logic               no_device,
  output logic [PCNT_W-1:0]  page_count,
  output logic [PSIZE_W-1:0] page_bytes,
  output logic [SHIFT_W-1:0] page_shift,
  output logic               binary_pages,
  output logic [TOTAL_W-1:0] total_bytes,
  output logic               spi_sck,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  input  logic               spi_miso
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic       x_start, x_done, x_busy;
  logic [7:0] x_tx, x_rx;
  logic [7:0] dhi, dlo, stat;
  logic       jknown, jbincap, labsent, lknown;
  geom_t      jbin, jext, lgeom, geom;

  fgp_spi_byte #(.CLK_HALF(CLK_HALF)) u_spi (
    .clk(clk), .rst_n(rst_sync_q), .start(x_start), .tx_byte(x_tx),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(x_busy),
    .done(x_done), .rx_byte(x_rx)
  );

  fgp_decode u_dec (
    .dev_hi(dhi), .dev_lo(dlo), .status(stat),
    .jed_known(jknown), .jed_bincap(jbincap),
    .jed_bin_geom(jbin), .jed_ext_geom(jext),
    .leg_absent(labsent), .leg_known(lknown), .leg_geom(lgeom)
  );

  fgp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_q), .probe_req(probe_req),
    .xfer_done(x_done), .rx_byte(x_rx), .xfer_start(x_start), .xfer_tx(x_tx),
    .cs_n(spi_cs_n), .dev_hi(dhi), .dev_lo(dlo), .status(stat),
    .jed_known(jknown), .jed_bincap(jbincap),
    .jed_bin_geom(jbin), .jed_ext_geom(jext),
    .leg_absent(labsent), .leg_known(lknown), .leg_geom(lgeom),
    .busy(busy), .done(done), .geom_valid(geom_valid),
    .unsupported(unsupported), .no_device(no_device), .geom(geom)
  );

  assign page_count   = geom.pages;
  assign page_bytes   = geom.psize;
  assign page_shift   = geom.shift;
  assign binary_pages = geom.bin;
  assign total_bytes  = geom.total;

  // R13
  cs_sck_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    spi_cs_n |-> !spi_sck);

  // R2
  shifter_framed_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    x_busy |-> !spi_cs_n);

  // R10
  total_prod_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    geom_valid |-> (32'(total_bytes) == 32'(page_count) * 32'(page_bytes)));

endmodule

// File: tb/tb_flash_geom_probe.sv
module tb_flash_geom_probe;
  localparam int CLK_HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic probe_req = 1'b0;
  always #2.5 clk = ~clk;

  logic        busy, done, geom_valid, unsupported, no_device;
  logic [13:0] page_count;
  logic [10:0] page_bytes;
  logic [3:0]  page_shift;
  logic        binary_pages;
  logic [23:0] total_bytes;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  flash_geom_probe #(.CLK_HALF(CLK_HALF)) dut (
    .clk(clk), .rst_n(rst_n), .probe_req(probe_req), .busy(busy), .done(done),
    .geom_valid(geom_valid), .unsupported(unsupported), .no_device(no_device),
    .page_count(page_count), .page_bytes(page_bytes), .page_shift(page_shift),
    .binary_pages(binary_pages), .total_bytes(total_bytes),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Device model: mode 0, MSB first.
  logic [7:0] s_mfr = 8'h00, s_dhi = 8'h00, s_dlo = 8'h00, s_stat = 8'h00;
  logic       s_absent = 1'b0;
  logic [7:0] opc = 8'h00;
  logic [7:0] rb;
  logic       miso_r = 1'b0;
  int         rcnt = 0;
  int         tcnt = 0;
  logic [7:0] op0, op1;
  int         bits0, bits1;

  assign spi_miso = s_absent ? 1'b1 : miso_r;

  function automatic logic [7:0] resp(input logic [7:0] op, input int idx);
    if (op == 8'h9F) return (idx == 0) ? s_mfr : (idx == 1) ? s_dhi : (idx == 2) ? s_dlo : 8'h00;
    if (op == 8'hD7) return s_stat;
    return 8'h00;
  endfunction

  always @(negedge spi_cs_n) begin rcnt = 0; opc = 8'h00; miso_r = 1'b0; end
  always @(posedge spi_sck) if (spi_cs_n == 1'b0) begin
    if (rcnt < 8) opc = {opc[6:0], spi_mosi};
    rcnt++;
  end
  always @(negedge spi_sck) if (spi_cs_n == 1'b0 && rcnt >= 8) begin
    rb = resp(opc, (rcnt - 8) / 8);
    miso_r = rb[7 - ((rcnt - 8) % 8)];
  end
  always @(posedge spi_cs_n) begin
    if (tcnt == 0) begin op0 = opc; bits0 = rcnt; end
    else if (tcnt == 1) begin op1 = opc; bits1 = rcnt; end
    tcnt++;
  end

  // Framing monitor (R13)
  int frame_bad = 0;
  int done_seen = 0;
  always @(negedge clk) if (rst_n) begin
    if (spi_cs_n === 1'b1 && spi_sck === 1'b1) frame_bad++;
    if (busy === 1'b0 && spi_cs_n !== 1'b1) frame_bad++;
    if (done === 1'b1) done_seen++;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected results
  logic        e_val, e_uns, e_nod, e_bin;
  logic [13:0] e_pages;
  logic [10:0] e_size;
  logic [3:0]  e_shift;
  logic [23:0] e_total;
  int          e_txn;
  string       e_req;

  task automatic calc_exp(input logic [7:0] m, input logic [15:0] id, input logic [7:0] st);
    int pg, ext, esh, bsz, bsh;
    bit cap, known;
    e_val = 0; e_uns = 0; e_nod = 0; e_bin = 0;
    pg = 0; ext = 0; esh = 0; bsz = 0; bsh = 0; cap = 1; known = 1;
    if (m == 8'h1F) begin
      e_req = "R4";
      case (id)
        16'h2200: begin pg = 512;  ext = 264;  esh = 9;  end
        16'h2300: begin pg = 1024; ext = 264;  esh = 9;  end
        16'h2400: begin pg = 2048; ext = 264;  esh = 9;  end
        16'h2500: begin pg = 4096; ext = 264;  esh = 9;  end
        16'h2600: begin pg = 4096; ext = 528;  esh = 10; end
        16'h2700: begin pg = 8192; ext = 528;  esh = 10; cap = 0; e_req = "R5"; end
        16'h2701: begin pg = 8192; ext = 528;  esh = 10; end
        16'h2800: begin pg = 8192; ext = 1056; esh = 11; end
        default:  begin known = 0; e_req = "R6"; end
      endcase
      bsz = ext - ext / 33; bsh = esh - 1;
      if (!known) begin e_uns = 1; e_txn = 1; end
      else if (!cap) begin e_val = 1; e_txn = 1; end
      else begin e_val = 1; e_txn = 2; e_bin = st[0]; end
    end else begin
      e_txn = 2;
      if (st == 8'h00 || st == 8'hFF) begin e_nod = 1; e_req = "R7"; end
      else begin
        e_req = "R8";
        case (st & 8'h3C)
          8'h0C: begin pg = 512;  ext = 264;  esh = 9;  end
          8'h14: begin pg = 1024; ext = 264;  esh = 9;  end
          8'h1C: begin pg = 2048; ext = 264;  esh = 9;  end
          8'h24: begin pg = 4096; ext = 264;  esh = 9;  end
          8'h2C: begin pg = 4096; ext = 528;  esh = 10; end
          8'h34: begin pg = 8192; ext = 528;  esh = 10; end
          8'h38, 8'h3C: begin pg = 8192; ext = 1056; esh = 11; end
          default: begin known = 0; e_req = "R9"; end
        endcase
        if (known) e_val = 1; else e_uns = 1;
      end
    end
    if (e_val) begin
      e_pages = 14'(pg);
      e_size  = e_bin ? 11'(bsz) : 11'(ext);
      e_shift = e_bin ? 4'(bsh) : 4'(esh);
      e_total = 24'(pg * int'(e_size));
    end else begin
      e_pages = '0; e_size = '0; e_shift = '0; e_total = '0;
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); probe_req = 1'b1;
    @(negedge clk); probe_req = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done === 1'b1) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic probe(input logic [7:0] m, input logic [7:0] dh, input logic [7:0] dl,
                       input logic [7:0] st, input bit absent);
    bit ok;
    logic [63:0] got, exp;
    s_mfr = m; s_dhi = dh; s_dlo = dl; s_stat = st; s_absent = absent;
    tcnt = 0;
    calc_exp(absent ? 8'hFF : m, {dh, dl}, absent ? 8'hFF : st);
    pulse_req();
    wait_done(ok);
    if (!ok) begin check(1'b0, "R11 timeout", 64'(0), 64'(1)); return; end
    got = {7'd0, geom_valid, unsupported, no_device, binary_pages, page_shift, page_bytes, page_count, total_bytes};
    exp = {7'd0, e_val, e_uns, e_nod, e_bin, e_shift, e_size, e_pages, e_total};
    check(got == exp, e_req, got, exp);
    // R2 R3: window count, opcodes and edge counts
    got = {32'(tcnt), op0, 24'(bits0)};
    exp = {32'(e_txn), 8'h9F, 24'd32};
    if (e_txn == 2) begin
      got = got ^ {8'd0, op1, 16'(bits1), 32'd0};
      exp = exp ^ {8'd0, 8'hD7, 16'd16, 32'd0};
    end
    check(got == exp, (e_txn == 2) ? "R3 windows" : "R2 windows", got, exp);
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] m;
    bit ok;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({spi_cs_n, spi_sck, busy, done, geom_valid, unsupported, no_device} == 7'b1000000,
          "R1 reset", 64'({spi_cs_n, spi_sck, busy, done, geom_valid, unsupported, no_device}), 64'h40);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({spi_cs_n, spi_sck, busy, done, geom_valid} == 5'b10000,
          "R1 after release", 64'({spi_cs_n, spi_sck, busy, done, geom_valid}), 64'h10);

    // JEDEC grid: known and unknown codes, both page-mode bits (R3 R4 R5 R6)
    for (int h = 8'h20; h <= 8'h29; h++)
      for (int l = 0; l < 3; l++)
        for (int b = 0; b < 2; b++)
          probe(8'h1F, 8'(h), 8'(l), 8'(8'hA4 | b), 1'b0);

    // Fallback path: every status byte (R7 R8 R9)
    for (int s = 0; s < 256; s++) begin
      m = 8'(s) ^ 8'hA5;
      if (m == 8'h1F) m = 8'h00;
      probe(m, 8'h27, 8'h01, 8'(s), 1'b0);
    end

    // No device at all: bus reads all ones (R7)
    probe(8'h00, 8'h00, 8'h00, 8'h00, 1'b1);

    // R12: flags clear on accept, busy requests ignored, fields hold
    probe(8'h1F, 8'h28, 8'h00, 8'h01, 1'b0);
    held = {page_count, page_bytes, page_shift, total_bytes};
    repeat (20) @(negedge clk);
    check({page_count, page_bytes, page_shift, total_bytes} == held[52:0] && geom_valid,
          "R12 hold", 64'({page_count, page_bytes, page_shift, total_bytes}), held);
    s_mfr = 8'h1F; s_dhi = 8'h99; s_dlo = 8'h00; s_absent = 1'b0; tcnt = 0;
    pulse_req();
    check(busy && !geom_valid && !unsupported && !no_device, "R12 clear",
          64'({busy, geom_valid, unsupported, no_device}), 64'h8);
    repeat (30) @(negedge clk);
    done_seen = 0;
    pulse_req();
    wait_done(ok);
    check(ok && unsupported && page_count == 14'd0 && page_bytes == 11'd0, "R11 zero fields",
          64'({unsupported, page_count, page_bytes}), 64'({1'b1, 25'd0}));
    repeat (600) @(negedge clk);
    check(done_seen == 1 && !busy && tcnt == 1, "R12 ignore busy req",
          64'({32'(done_seen), 32'(tcnt)}), 64'({32'd1, 32'd1}));

    // R13 framing over the whole run
    check(frame_bad == 0, "R13 framing", 64'(frame_bad), 64'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule